// File: doc/BRIEF.md
# Shared-Pin Strap Capture and Output Gating Controller

This block sits between a video receiver's core and its parallel output pads, where the same pads serve two purposes. While the part comes out of power-down the pads are released so that external pull resistors set their levels; the block reads those levels once as configuration straps and keeps them. After that it drives the pads as outputs. These outputs carry the pixel data, horizontal sync, vertical sync, data enable and pixel clock.

What reaches the pads depends on several conditions: whether the straps have been captured, the power-down input, the link lock status, a captured sleep-state strap and a captured hold-low strap. When the hold-low strap is set, the pads stay low until software writes a release bit. That bit stays set until the next power-down. The block registers all pad values and enables, so every pad changes one clock after the condition that moves it.

Top module: `strap_pin_ctrl`

## Requirements
- R1: After reset, and during power-down before any straps have been captured, every pad enable is 0 and `strap_valid` is 0.
- R2: The clock edge that first sees `pdn_n` high starts a capture window of CAPT_CYCLES clocks. `strap_pad_in` is stored into `strap_word` on the edge CAPT_CYCLES clocks after that first edge, and `strap_valid` rises on that same edge. Pads stay high-impedance through that edge. If `pdn_n` drops inside the window, nothing is captured.
- R3: After capture, changes on `strap_pad_in` have no effect on `strap_word` until the next release from power-down.
- R4: Pad enables can first turn on at the clock edge after the capture edge.
- R5: The pad bit layout is: bits [DATA_W-1:0] carry data, bit DATA_W carries hsync, DATA_W+1 vsync, DATA_W+2 data enable and DATA_W+3 pixel clock. When the block is running, locked, and either the hold strap is 0 or the release bit is set, the pads carry the video inputs one clock later with all enables at 1.
- R6: The sleep state uses strap bit SLEEP_POS (default 1). A value of 0 drives all pads low and a value of 1 makes them high-impedance. While running with the hold strap at 0, a low `link_lock` produces the sleep state on the next clock.
- R7: Strap bit HOLD_POS (default 0) selects hold-low. When it is 1, the pads are driven low after power-up whatever the lock state, until `rel_wr` is sampled high while the block is running. Video then appears one clock after that write. A write made before the block is running is ignored.
- R8: When the hold strap is 1, it overrides the sleep-state strap: every sleep-state condition drives the pads low.
- R9: Asserting `pdn_n` low after a capture produces the sleep state on the next clock, regardless of lock. It keeps the captured straps and clears the release bit, so hold-low applies again after the next power-up.
- R10: All pad enables always carry the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pdn_n | input | 1 | Power-down, active low |
| link_lock | input | 1 | Link lock status |
| rel_wr | input | 1 | Register write that sets the hold-low release bit |
| vid_data | input | DATA_W | Pixel data from the core |
| vid_hs | input | 1 | Horizontal sync from the core |
| vid_vs | input | 1 | Vertical sync from the core |
| vid_de | input | 1 | Data enable from the core |
| vid_pclk | input | 1 | Pixel clock level from the core |
| strap_pad_in | input | DATA_W | Pad levels read back as straps |
| pad_out | output | DATA_W+4 | Pad output values |
| pad_oe | output | DATA_W+4 | Pad output enables |
| strap_word | output | DATA_W | Captured strap values |
| strap_valid | output | 1 | Straps captured for the current power-up |

## Verification
The assertions check four things on every cycle: that the enables move as one group, that the pads stay high-impedance until straps are valid, that the hold-low, sleep and video output selections follow the running state one clock later, and that the straps stay stable and the release bit clears during power-down. Only the bench scenarios can show the exact capture edge and the captured value, that a release write during the capture window is ignored, that hold-low comes back after a power-down cycle, and that an aborted window captures nothing. The bench sweeps every combination of the hold and sleep straps against lock, release and power-down.

// File: rtl/spc_pkg.sv
package spc_pkg;

    typedef enum logic [1:0] {
        PH_OFF  = 2'd0,
        PH_CAPT = 2'd1,
        PH_RUN  = 2'd2
    } phase_e;

    typedef enum logic [1:0] {
        OM_HIZ   = 2'd0,
        OM_LOW   = 2'd1,
        OM_VIDEO = 2'd2
    } omode_e;

    typedef struct packed {
        logic hold;
        logic sleep_hiz;
    } sleep_cfg_t;

    // Output state used whenever video must not reach the pads.
    function automatic omode_e idle_mode(sleep_cfg_t c);
        if (c.hold)
            return OM_LOW;
        else if (c.sleep_hiz)
            return OM_HIZ;
        else
            return OM_LOW;
    endfunction

endpackage

// File: rtl/spc_capture.sv
module spc_capture
    import spc_pkg::*;
#(
    parameter int SW          = 8,
    parameter int CAPT_CYCLES = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pdn_n,
    input  logic [SW-1:0] pad_strap,
    output phase_e        phase,
    output logic [SW-1:0] strap_q,
    output logic          valid
);
    localparam int CW = (CAPT_CYCLES > 1) ? $clog2(CAPT_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(CAPT_CYCLES - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_OFF;
            cnt     <= '0;
            strap_q <= '0;
            valid   <= 1'b0;
        end else if (!pdn_n) begin
            phase <= PH_OFF;
            cnt   <= '0;
        end else begin
            case (phase)
                PH_OFF: begin
                    phase <= PH_CAPT;
                    cnt   <= '0;
                    valid <= 1'b0;
                end
                PH_CAPT: begin
                    if (cnt == LAST) begin
                        phase   <= PH_RUN;
                        strap_q <= pad_strap;
                        valid   <= 1'b1;
                    end else begin
                        cnt <= cnt + CW'(1);
                    end
                end
                default: phase <= PH_RUN;
            endcase
        end
    end
endmodule

// File: rtl/spc_release.sv
module spc_release (
    input  logic clk,
    input  logic rst,
    input  logic pdn_n,
    input  logic running,
    input  logic rel_wr,
    output logic rel_q
);
    always_ff @(posedge clk) begin
        if (rst || !pdn_n)
            rel_q <= 1'b0;
        else if (rel_wr && running)
            rel_q <= 1'b1;
    end
endmodule

// File: rtl/spc_mode.sv
module spc_mode
    import spc_pkg::*;
(
    input  logic       pdn_n,
    input  phase_e     phase,
    input  logic       valid,
    input  sleep_cfg_t cfg,
    input  logic       lock,
    input  logic       rel,
    output omode_e     mode
);
    always_comb begin
        if (!pdn_n)
            mode = valid ? idle_mode(cfg) : OM_HIZ;
        else if (phase != PH_RUN)
            mode = OM_HIZ;
        else if (cfg.hold && !rel)
            mode = OM_LOW;
        else if (!lock)
            mode = idle_mode(cfg);
        else
            mode = OM_VIDEO;
    end
endmodule

// File: rtl/spc_pad_reg.sv
module spc_pad_reg
    import spc_pkg::*;
#(
    parameter int NP = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  omode_e        mode,
    input  logic [NP-1:0] vid,
    output logic [NP-1:0] pad_out,
    output logic [NP-1:0] pad_oe
);
    for (genvar i = 0; i < NP; i++) begin : g_pin
        logic o_q, e_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                o_q <= 1'b0;
                e_q <= 1'b0;
            end else begin
                e_q <= (mode != OM_HIZ);
                o_q <= (mode == OM_VIDEO) ? vid[i] : 1'b0;
            end
        end
        assign pad_out[i] = o_q;
        assign pad_oe[i]  = e_q;
    end
endmodule

// File: rtl/strap_pin_ctrl.sv
module strap_pin_ctrl
    import spc_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int CAPT_CYCLES = 8,
    parameter int HOLD_POS    = 0,
    parameter int SLEEP_POS   = 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                pdn_n,
    input  logic                link_lock,
    input  logic                rel_wr,
    input  logic [DATA_W-1:0]   vid_data,
    input  logic                vid_hs,
    input  logic                vid_vs,
    input  logic                vid_de,
    input  logic                vid_pclk,
    input  logic [DATA_W-1:0]   strap_pad_in,
    output logic [DATA_W+3:0]   pad_out,
    output logic [DATA_W+3:0]   pad_oe,
    output logic [DATA_W-1:0]   strap_word,
    output logic                strap_valid
);
    localparam int PAD_W = DATA_W + 4;

    phase_e     phase_w;
    logic       rel_w;
    sleep_cfg_t cfg_w;
    omode_e     mode_w;
    logic [PAD_W-1:0] vid_bus;

    assign vid_bus         = {vid_pclk, vid_de, vid_vs, vid_hs, vid_data};
    assign cfg_w.hold      = strap_word[HOLD_POS];
    assign cfg_w.sleep_hiz = strap_word[SLEEP_POS];

    spc_capture #(.SW(DATA_W), .CAPT_CYCLES(CAPT_CYCLES)) cap_i (
        .clk(clk), .rst(rst), .pdn_n(pdn_n), .pad_strap(strap_pad_in),
        .phase(phase_w), .strap_q(strap_word), .valid(strap_valid)
    );

    spc_release rel_i (
        .clk(clk), .rst(rst), .pdn_n(pdn_n),
        .running(phase_w == PH_RUN), .rel_wr(rel_wr), .rel_q(rel_w)
    );

    spc_mode mode_i (
        .pdn_n(pdn_n), .phase(phase_w), .valid(strap_valid), .cfg(cfg_w),
        .lock(link_lock), .rel(rel_w), .mode(mode_w)
    );

    spc_pad_reg #(.NP(PAD_W)) pads_i (
        .clk(clk), .rst(rst), .mode(mode_w), .vid(vid_bus),
        .pad_out(pad_out), .pad_oe(pad_oe)
    );
endmodule

// File: rtl/spc_checker.sv
module spc_checker
    import spc_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int HOLD_POS  = 0,
    parameter int SLEEP_POS = 1
) (
    input logic              clk,
    input logic              rst,
    input logic              pdn_n,
    input logic              link_lock,
    input logic [DATA_W-1:0] vid_data,
    input logic              vid_hs,
    input logic              vid_vs,
    input logic              vid_de,
    input logic              vid_pclk,
    input logic [DATA_W+3:0] pad_out,
    input logic [DATA_W+3:0] pad_oe,
    input logic [DATA_W-1:0] strap_word,
    input logic              strap_valid,
    input phase_e            phase,
    input logic              rel_q
);
    localparam int PAD_W = DATA_W + 4;
    localparam logic [PAD_W-1:0] ALL1 = '1;

    logic hold, sleep, running;
    logic [PAD_W-1:0] vbus;
    assign hold    = strap_word[HOLD_POS];
    assign sleep   = strap_word[SLEEP_POS];
    assign running = pdn_n && (phase == PH_RUN);
    assign vbus    = {vid_pclk, vid_de, vid_vs, vid_hs, vid_data};

    p_hiz_unstrapped_r1: assert property (@(posedge clk) disable iff (rst)
        !strap_valid |=> (pad_oe == '0));

    p_straps_held_r3: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_RUN) |=> $stable(strap_word));

    p_video_pass_r5: assert property (@(posedge clk) disable iff (rst)
        (running && link_lock && (!hold || rel_q)) |=> (pad_oe == ALL1 && pad_out == $past(vbus)));

    p_unlock_hiz_r6: assert property (@(posedge clk) disable iff (rst)
        (running && !link_lock && !hold && sleep) |=> (pad_oe == '0));

    p_hold_low_r7: assert property (@(posedge clk) disable iff (rst)
        (running && hold && !rel_q) |=> (pad_oe == ALL1 && pad_out == '0));

    p_hold_over_sleep_r8: assert property (@(posedge clk) disable iff (rst)
        (!pdn_n && strap_valid && hold) |=> (pad_oe == ALL1 && pad_out == '0));

    p_release_clear_r9: assert property (@(posedge clk) disable iff (rst)
        !pdn_n |=> !rel_q);

    p_oe_group_r10: assert property (@(posedge clk) disable iff (rst)
        (pad_oe == '0) || (pad_oe == ALL1));
endmodule

bind strap_pin_ctrl spc_checker #(
    .DATA_W(DATA_W), .HOLD_POS(HOLD_POS), .SLEEP_POS(SLEEP_POS)
) chk_i (
    .clk(clk), .rst(rst), .pdn_n(pdn_n), .link_lock(link_lock),
    .vid_data(vid_data), .vid_hs(vid_hs), .vid_vs(vid_vs), .vid_de(vid_de),
    .vid_pclk(vid_pclk), .pad_out(pad_out), .pad_oe(pad_oe),
    .strap_word(strap_word), .strap_valid(strap_valid),
    .phase(phase_w), .rel_q(rel_w)
);

// File: tb/strap_pin_ctrl_tb_top.sv
module strap_pin_ctrl_tb_top;
    localparam int DW = 8;
    localparam int CC = 8;
    localparam int HP = 0;
    localparam int SP = 1;
    localparam int PW = DW + 4;
    localparam logic [31:0] ALL = (32'd1 << PW) - 32'd1;

    logic clk = 1'b0, rst = 1'b1, pdn_n = 1'b0, link_lock = 1'b0, rel_wr = 1'b0;
    logic [DW-1:0] vid_data = '0, strap_pad_in = '0;
    logic vid_hs = 1'b0, vid_vs = 1'b0, vid_de = 1'b0, vid_pclk = 1'b0;
    logic [PW-1:0] pad_out, pad_oe;
    logic [DW-1:0] strap_word;
    logic strap_valid;
    int total = 0, bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    strap_pin_ctrl #(.DATA_W(DW), .CAPT_CYCLES(CC), .HOLD_POS(HP), .SLEEP_POS(SP)) dut_i (
        .clk(clk), .rst(rst), .pdn_n(pdn_n), .link_lock(link_lock), .rel_wr(rel_wr),
        .vid_data(vid_data), .vid_hs(vid_hs), .vid_vs(vid_vs), .vid_de(vid_de),
        .vid_pclk(vid_pclk), .strap_pad_in(strap_pad_in), .pad_out(pad_out),
        .pad_oe(pad_oe), .strap_word(strap_word), .strap_valid(strap_valid)
    );

    task automatic tick;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic drive_vid(input int seed);
        {vid_pclk, vid_de, vid_vs, vid_hs, vid_data} = PW'(seed * 613 + 91);
    endtask

    // 0 = high-impedance, 1 = driven low, 2 = video
    function automatic int idle_m(input bit h, input bit s);
        return (h || !s) ? 1 : 0;
    endfunction

    task automatic chk_mode(input string tag, input int m);
        logic [31:0] vb;
        vb = 32'({vid_pclk, vid_de, vid_vs, vid_hs, vid_data});
        chk({tag, " /R10 enables"}, 32'(pad_oe), (m == 0) ? 32'd0 : ALL);
        chk({tag, " data"}, 32'(pad_out), (m == 2) ? vb : 32'd0);
    endtask

    task automatic power_up(input logic [DW-1:0] p, input bit wr_mid);
        strap_pad_in = p;
        pdn_n = 1'b1;
        for (int i = 0; i <= CC; i++) begin
            rel_wr = wr_mid && (i == 3);
            tick;
            chk("R2 pads hi-Z in window", 32'(pad_oe), 32'd0);
            chk("R2 strap_valid timing", 32'(strap_valid), 32'(i == CC));
        end
        rel_wr = 1'b0;
        chk("R2 captured straps", 32'(strap_word), 32'(p));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) tick;
        rst = 1'b0;
        tick;
        chk("R1 reset enables", 32'(pad_oe), 32'd0);
        chk("R1 reset strap_valid", 32'(strap_valid), 32'd0);

        for (int k = 0; k < 4; k++) begin
            bit h, s;
            logic [DW-1:0] p;
            h = k[0];
            s = k[1];
            p = DW'(8'h5A + k * 37);
            p[HP] = h;
            p[SP] = s;

            rst = 1'b1;
            tick;
            rst = 1'b0;
            pdn_n = 1'b0;
            tick;
            tick;
            chk("R1 power-down before capture", 32'(pad_oe), 32'd0);
            chk("R1 no straps yet", 32'(strap_valid), 32'd0);

            power_up(p, 1'b1);

            strap_pad_in = ~p;
            link_lock = 1'b0;
            drive_vid(k);
            tick;
            chk_mode("R4 first driven edge", idle_m(h, s));
            chk("R3 straps held", 32'(strap_word), 32'(p));

            for (int c = 0; c < 8; c++) begin
                link_lock = c[1];
                drive_vid(c + 10 * k);
                tick;
                if (h)
                    chk_mode("R7 hold low before release", 1);
                else if (link_lock)
                    chk_mode("R5 locked video", 2);
                else
                    chk_mode("R6 unlocked sleep state", idle_m(h, s));
            end
            chk("R3 straps held after sweep", 32'(strap_word), 32'(p));

            link_lock = 1'b1;
            rel_wr = 1'b1;
            drive_vid(50 + k);
            tick;
            rel_wr = 1'b0;
            chk_mode("R7 write edge", h ? 1 : 2);
            drive_vid(60 + k);
            tick;
            chk_mode("R7 video after release", 2);

            link_lock = 1'b0;
            drive_vid(70 + k);
            tick;
            chk_mode(h ? "R8 hold overrides sleep on lock drop" : "R6 lock drop", idle_m(h, s));

            link_lock = 1'b1;
            drive_vid(80 + k);
            tick;
            chk_mode("R5 relock video", 2);

            pdn_n = 1'b0;
            drive_vid(90 + k);
            tick;
            chk_mode(h ? "R8 power-down hold low" : "R9 power-down sleep state", idle_m(h, s));
            chk("R9 straps kept in power-down", 32'(strap_valid), 32'd1);
            drive_vid(95 + k);
            tick;
            chk_mode("R9 lock ignored in power-down", idle_m(h, s));

            power_up(p, 1'b0);
            link_lock = 1'b1;
            drive_vid(100 + k);
            tick;
            chk_mode("R9 release cleared by power-down", h ? 1 : 2);
        end

        rst = 1'b1;
        tick;
        rst = 1'b0;
        strap_pad_in = 8'hC3;
        pdn_n = 1'b1;
        repeat (3) tick;
        pdn_n = 1'b0;
        repeat (CC + 2) tick;
        chk("R2 aborted window no capture", 32'(strap_valid), 32'd0);
        chk("R2 aborted window hi-Z", 32'(pad_oe), 32'd0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule